// File: doc/BRIEF.md
# Byte-Serial Link Transaction Deframer

This block sits behind the receive pins of a narrow point-to-point link. Each clock it takes one byte and a frame qualifier. From that stream it rebuilds whole transactions: a 4-bit control mode, a 32-bit destination address, a 2-bit size code, write and access flags, and one or two 32-bit data words. For a read, the first word is the requester's return address. When a transaction is complete, the assembled fields appear in parallel together with a one-cycle valid strobe.

A transaction starts on the first cycle in which the frame qualifier is high. The byte positions within a transaction are fixed, so decoding needs no length field. A 64-bit write sends its low word before its high word. If the sender keeps the frame high after a 64-bit write, the following bytes form header-less burst beats. Each beat is addressed one step above the previous transaction and keeps that transaction's other fields. If the frame drops partway through a transaction, the partial transaction is thrown away.

Top module: `lnk_deframer`

## Requirements
- R1: After reset, `txn_valid` is low and every output field reads zero.
- R2: The byte sampled in the first framed cycle (position 0) must be 8'h00. Any other value makes the block ignore the rest of that frame: no valid is produced until the frame goes low and rises again.
- R3: Header positions are fixed. Position 1 gives control[3:0] in bits 7:4 and dst[31:28] in bits 3:0. Positions 2, 3 and 4 give dst[27:20], dst[19:12] and dst[11:4]. Position 5 gives dst[3:0] in bits 7:4, the size code in bits 3:2, the write flag in bit 1 and the access flag in bit 0.
- R4: Positions 6 to 9 carry the low word, most significant byte first. For a read, this word is the return address. A transaction is wide only when its size code is 2'b11 and its write flag is 1. A transaction that is not wide completes at position 9, and its `txn_word_hi` reads zero.
- R5: A wide transaction also carries the high word at positions 10 to 13, most significant byte first, and completes at position 13.
- R6: If the frame stays high after a wide transaction, every further 8 bytes form one burst beat. The beat carries the low word first, then the high word, each most significant byte first. Its destination is the previous transaction's destination plus 8, and it reuses control, size code, write and access.
- R7: If the frame goes low before a transaction completes, the partial transaction is discarded with no valid. The next rise of the frame starts a fresh transaction at position 0.
- R8: `txn_valid` is high for exactly one cycle. It is registered on the clock edge that samples the final byte, so it appears in the cycle after that byte is presented.
- R9: After a transaction that is not wide completes, bytes received while the frame stays high are ignored, and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock; one byte is sampled per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_frame | input | 1 | Frame qualifier; high while a transaction or burst is in flight |
| lnk_byte | input | BW | Received link byte |
| txn_valid | output | 1 | One-cycle strobe; the fields below are valid |
| txn_ctrl | output | 4 | Control mode |
| txn_dst | output | AW | Destination address |
| txn_dmode | output | 2 | Size code |
| txn_write | output | 1 | Write flag |
| txn_access | output | 1 | Access flag |
| txn_word_lo | output | DW | Low data word, or return address for reads |
| txn_word_hi | output | DW | High data word of a wide write, otherwise zero |

## Verification
The assertions check on every cycle that:
- the valid strobe never lasts two cycles;
- a low frame forces the parser back to idle and produces no strobe on the next edge;
- a non-zero leading byte sends the parser into its ignore state;
- every burst beat's address is exactly one step above the previously emitted address.

Only the bench's scenarios can show that each field is taken from the correct byte position and that the word order is right. The same holds for the bench's checks that an aborted frame, a bad lead byte and trailing bytes after a narrow transaction produce no strobe and leave the outputs unchanged.

// File: rtl/dfr_pkg.sv
package dfr_pkg;
   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_BODY  = 2'd1,
      S_BEAT  = 2'd2,
      S_DRAIN = 2'd3
   } dfr_st_e;

   localparam int POS_W     = 4;
   localparam int POS_HDR   = 5;
   localparam int POS_LO_END = 9;
   localparam int POS_HI_END = 13;
   localparam int BEAT_LEN  = 8;
   localparam int BEAT_BASE = 6;
endpackage

// File: rtl/dfr_seq.sv
module dfr_seq
   import dfr_pkg::*;
#(
   parameter int BW       = 8,
   parameter bit BURST_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frm,
   input  logic [BW-1:0]    din,
   input  logic             is_wide,
   output logic             cap_en,
   output logic [POS_W-1:0] cap_idx,
   output logic             emit,
   output logic             step
);
   localparam logic [POS_W-1:0] LO_END = POS_W'(POS_LO_END);
   localparam logic [POS_W-1:0] HI_END = POS_W'(POS_HI_END);
   localparam logic [POS_W-1:0] B_LAST = POS_W'(BEAT_LEN - 1);
   localparam logic [POS_W-1:0] B_BASE = POS_W'(BEAT_BASE);

   dfr_st_e          st;
   logic [POS_W-1:0] pos;
   logic             burst_ok;

   generate
      if (BURST_EN) begin : g_burst
         assign burst_ok = 1'b1;
      end else begin : g_noburst
         assign burst_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      cap_en  = frm && (st == S_BODY || st == S_BEAT);
      cap_idx = (st == S_BEAT) ? pos + B_BASE : pos;
      emit    = cap_en && (((st == S_BODY) && (pos == LO_END) && !is_wide) ||
                           ((st == S_BODY) && (pos == HI_END)) ||
                           ((st == S_BEAT) && (pos == B_LAST)));
      step    = cap_en && (st == S_BEAT) && (pos == B_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !frm) begin
         st  <= S_IDLE;
         pos <= '0;
      end else begin
         unique case (st)
            S_IDLE: begin
               st  <= (din == '0) ? S_BODY : S_DRAIN;
               pos <= POS_W'(1);
            end
            S_BODY: begin
               if (pos == LO_END && !is_wide) begin
                  st <= S_DRAIN;
               end else if (pos == HI_END) begin
                  st  <= burst_ok ? S_BEAT : S_DRAIN;
                  pos <= '0;
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            S_BEAT:  pos <= (pos == B_LAST) ? '0 : pos + 1'b1;
            default: st  <= S_DRAIN;
         endcase
      end
   end

   // R2: a non-zero lead byte sends the parser to its ignore state
   a_r2_bad_lead: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_IDLE && frm && din != '0) |=> (st == S_DRAIN));
   // R7: a low frame returns the parser to idle
   a_r7_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !frm |=> (st == S_IDLE && pos == '0));
   // R5: captured positions stay within the 14-byte layout
   a_r5_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |-> (cap_idx != '0 && cap_idx <= HI_END));
endmodule

// File: rtl/dfr_pack.sv
module dfr_pack
   import dfr_pkg::*;
#(
   parameter int BW   = 8,
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int STEP = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BW-1:0]    din,
   input  logic             cap_en,
   input  logic [POS_W-1:0] cap_idx,
   input  logic             emit,
   input  logic             step,
   output logic             is_wide,
   output logic             o_valid,
   output logic [3:0]       o_ctrl,
   output logic [AW-1:0]    o_dst,
   output logic [1:0]       o_dmode,
   output logic             o_wr,
   output logic             o_acc,
   output logic [DW-1:0]    o_lo,
   output logic [DW-1:0]    o_hi
);
   localparam int NB = DW / BW;

   logic [3:0]    ctrl_w, ctrl_n;
   logic [AW-1:0] dst_w,  dst_n;
   logic [1:0]    dm_w,   dm_n;
   logic          wr_w,   wr_n;
   logic          acc_w,  acc_n;
   logic [DW-1:0] lo_w,   lo_n;
   logic [DW-1:0] hi_w,   hi_n;
   logic [AW-1:0] dst_emit;

   assign is_wide = (dm_w == 2'b11) && wr_w;

   always_comb begin
      ctrl_n = ctrl_w; dst_n = dst_w; dm_n = dm_w;
      wr_n = wr_w; acc_n = acc_w; lo_n = lo_w; hi_n = hi_w;
      unique case (cap_idx)
         POS_W'(1): begin ctrl_n = din[7:4]; dst_n[31:28] = din[3:0]; end
         POS_W'(2): dst_n[27:20] = din;
         POS_W'(3): dst_n[19:12] = din;
         POS_W'(4): dst_n[11:4]  = din;
         POS_W'(POS_HDR): begin
            dst_n[3:0] = din[7:4];
            dm_n       = din[3:2];
            wr_n       = din[1];
            acc_n      = din[0];
         end
         default: ;
      endcase
      for (int k = 0; k < NB; k++) begin
         if (cap_idx == POS_W'(POS_LO_END - k)) lo_n[BW*k +: BW] = din;
         if (cap_idx == POS_W'(POS_HI_END - k)) hi_n[BW*k +: BW] = din;
      end
      dst_emit = step ? dst_w + AW'(STEP) : dst_n;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_w <= '0; dst_w <= '0; dm_w <= '0; wr_w <= 1'b0; acc_w <= 1'b0;
         lo_w <= '0; hi_w <= '0;
         o_valid <= 1'b0; o_ctrl <= '0; o_dst <= '0; o_dmode <= '0;
         o_wr <= 1'b0; o_acc <= 1'b0; o_lo <= '0; o_hi <= '0;
      end else begin
         o_valid <= emit;
         if (cap_en) begin
            ctrl_w <= ctrl_n; dst_w <= dst_emit; dm_w <= dm_n;
            wr_w <= wr_n; acc_w <= acc_n; lo_w <= lo_n; hi_w <= hi_n;
         end
         if (emit) begin
            o_ctrl  <= ctrl_n;
            o_dst   <= dst_emit;
            o_dmode <= dm_n;
            o_wr    <= wr_n;
            o_acc   <= acc_n;
            o_lo    <= lo_n;
            o_hi    <= (dm_n == 2'b11 && wr_n) ? hi_n : '0;
         end
      end
   end

   // R8: the strobe never lasts two cycles
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      o_valid |=> !o_valid);
   // R6: each burst beat is addressed one step above the previous emission
   a_r6_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> (o_valid && o_dst == $past(o_dst) + AW'(STEP)));
endmodule

// File: rtl/lnk_deframer.sv
module lnk_deframer
   import dfr_pkg::*;
#(
   parameter int BW       = 8,
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int STEP     = 8,
   parameter bit BURST_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lnk_frame,
   input  logic [BW-1:0] lnk_byte,
   output logic          txn_valid,
   output logic [3:0]    txn_ctrl,
   output logic [AW-1:0] txn_dst,
   output logic [1:0]    txn_dmode,
   output logic          txn_write,
   output logic          txn_access,
   output logic [DW-1:0] txn_word_lo,
   output logic [DW-1:0] txn_word_hi
);
   generate
      if (BW != 8 || AW != 32 || DW != 32) begin : g_bad_width
         $error("lnk_deframer: header layout fixes BW=8, AW=32, DW=32");
      end
      if (STEP <= 0) begin : g_bad_step
         $error("lnk_deframer: STEP must be positive");
      end
   endgenerate

   logic             cap_en, emit, step, is_wide;
   logic [POS_W-1:0] cap_idx;

   dfr_seq #(.BW(BW), .BURST_EN(BURST_EN)) u_seq (
      .clk(clk), .rst_n(rst_n), .frm(lnk_frame), .din(lnk_byte),
      .is_wide(is_wide), .cap_en(cap_en), .cap_idx(cap_idx),
      .emit(emit), .step(step)
   );

   dfr_pack #(.BW(BW), .AW(AW), .DW(DW), .STEP(STEP)) u_pack (
      .clk(clk), .rst_n(rst_n), .din(lnk_byte), .cap_en(cap_en),
      .cap_idx(cap_idx), .emit(emit), .step(step), .is_wide(is_wide),
      .o_valid(txn_valid), .o_ctrl(txn_ctrl), .o_dst(txn_dst),
      .o_dmode(txn_dmode), .o_wr(txn_write), .o_acc(txn_access),
      .o_lo(txn_word_lo), .o_hi(txn_word_hi)
   );

   // R7: a low frame yields no strobe on the next edge
   a_r7_no_valid_unframed: assert property (@(posedge clk) disable iff (!rst_n)
      !lnk_frame |=> !txn_valid);
endmodule

// File: tb/sim_lnk_deframer.sv
module sim_lnk_deframer;
   typedef struct packed {
      logic [3:0]  ctrl;
      logic [31:0] dst;
      logic [1:0]  dm;
      logic        wr;
      logic        acc;
      logic [31:0] lo;
      logic [31:0] hi;
   } vec_t;

   localparam int NV = 4;
   localparam vec_t VEC [NV] = '{
      '{4'h5, 32'h8123_4567, 2'd2, 1'b1, 1'b1, 32'hDEAD_BEEF, 32'h0},
      '{4'hA, 32'h0F0E_0D0C, 2'd2, 1'b0, 1'b1, 32'h1234_5678, 32'h0},
      '{4'h3, 32'h4000_0010, 2'd3, 1'b1, 1'b1, 32'hCAFE_F00D, 32'h0BAD_C0DE},
      '{4'h0, 32'hFFFF_FFF8, 2'd1, 1'b1, 1'b0, 32'h0000_A5A5, 32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frm = 1'b0;
   logic [7:0]  din = '0;
   logic        vld;
   logic [3:0]  o_ctrl;
   logic [31:0] o_dst, o_lo, o_hi;
   logic [1:0]  o_dm;
   logic        o_wr, o_acc;

   int checks = 0;
   int fails  = 0;
   int vcnt   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   lnk_deframer u0 (
      .clk(clk), .rst_n(rst_n), .lnk_frame(frm), .lnk_byte(din),
      .txn_valid(vld), .txn_ctrl(o_ctrl), .txn_dst(o_dst), .txn_dmode(o_dm),
      .txn_write(o_wr), .txn_access(o_acc), .txn_word_lo(o_lo), .txn_word_hi(o_hi)
   );

   function automatic logic [103:0] outs();
      return {o_ctrl, o_dst, o_dm, o_wr, o_acc, o_lo, o_hi};
   endfunction

   function automatic bit wide(vec_t v);
      return (v.dm == 2'b11) && v.wr;
   endfunction

   function automatic logic [103:0] expect_of(vec_t v);
      vec_t e = v;
      if (!wide(v)) e.hi = '0;
      return e;
   endfunction

   function automatic logic [7:0] byte_at(vec_t v, int k);
      case (k)
         0: return 8'h00;
         1: return {v.ctrl, v.dst[31:28]};
         2: return v.dst[27:20];
         3: return v.dst[19:12];
         4: return v.dst[11:4];
         5: return {v.dst[3:0], v.dm, v.wr, v.acc};
         6, 7, 8, 9: return v.lo[8*(9-k) +: 8];
         default: return v.hi[8*(13-k) +: 8];
      endcase
   endfunction

   task automatic chk(bit ok, string req, logic [103:0] act, logic [103:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic put(logic f, logic [7:0] b);
      frm = f;
      din = b;
      @(negedge clk);
      if (vld) vcnt++;
   endtask

   task automatic send(vec_t v, int upto);
      for (int k = 0; k <= upto; k++) put(1'b1, byte_at(v, k));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      vec_t bv;
      int   c0;
      logic [103:0] held;
      @(negedge clk);
      @(negedge clk);
      // R1: reset state
      chk(vld == 1'b0 && outs() == '0, "R1 reset", {103'd0, vld}, '0);
      rst_n = 1'b1;
      put(1'b0, 8'h00);

      // Table walk: R3, R4, R5, R8
      for (int i = 0; i < NV; i++) begin
         c0 = vcnt;
         send(VEC[i], wide(VEC[i]) ? 13 : 9);
         chk(vld == 1'b1, wide(VEC[i]) ? "R5 valid at pos 13" : "R4 valid at pos 9",
             {103'd0, vld}, 104'd1);
         chk(outs() == expect_of(VEC[i]), "R3 fields", outs(), expect_of(VEC[i]));
         put(1'b0, 8'h00);
         chk(vld == 1'b0 && vcnt == c0 + 1, "R8 single pulse",
             {71'd0, vld, 32'(vcnt - c0)}, {72'd0, 32'd1});
      end

      // R2: non-zero lead byte ignores the frame
      c0 = vcnt;
      held = outs();
      put(1'b1, 8'h01);
      for (int k = 1; k <= 9; k++) put(1'b1, byte_at(VEC[0], k));
      put(1'b0, 8'h00);
      chk(vcnt == c0 && outs() == held, "R2 bad lead ignored", outs(), held);

      // R7: abort mid transaction, then a fresh frame decodes
      c0 = vcnt;
      send(VEC[2], 7);
      put(1'b0, 8'h00);
      chk(vcnt == c0 && outs() == held, "R7 abort no valid", outs(), held);
      send(VEC[1], 9);
      chk(vld == 1'b1 && outs() == expect_of(VEC[1]), "R7 fresh frame",
          outs(), expect_of(VEC[1]));
      put(1'b0, 8'h00);

      // R6: burst with two beats after a wide write
      send(VEC[2], 13);
      chk(vld == 1'b1 && outs() == expect_of(VEC[2]), "R6 burst head",
          outs(), expect_of(VEC[2]));
      for (int b = 1; b <= 2; b++) begin
         bv     = VEC[2];
         bv.dst = VEC[2].dst + 32'(8 * b);
         bv.lo  = (b == 1) ? 32'h1111_2222 : 32'h5555_6666;
         bv.hi  = (b == 1) ? 32'h3333_4444 : 32'h7777_8888;
         for (int k = 6; k <= 13; k++) put(1'b1, byte_at(bv, k));
         chk(vld == 1'b1 && outs() == expect_of(bv), "R6 burst beat",
             outs(), expect_of(bv));
      end
      put(1'b0, 8'h00);

      // R9: trailing bytes after a narrow transaction are ignored
      send(VEC[0], 9);
      held = outs();
      c0 = vcnt;
      for (int k = 0; k < 10; k++) put(1'b1, 8'(8'h30 + k));
      chk(vcnt == c0 && outs() == held, "R9 trailing ignored", outs(), held);
      put(1'b0, 8'h00);

      // R1: reset mid stream clears outputs
      send(VEC[2], 4);
      rst_n = 1'b0;
      put(1'b0, 8'h00);
      chk(vld == 1'b0 && outs() == '0, "R1 reset clears", outs(), '0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule